// File: doc/BRIEF.md
# Trap-Level Privileged Register File

This block keeps the privileged control state of one processor strand and makes it reachable through a single register-number port with separate read and write strobes. Five small stacks hold the state saved on each trap (saved PC, saved next PC, saved machine state, trap type and the hypervisor-level saved state). All five are indexed by the current trap level, so software always reaches the entry of the level it is running at. Beside the stacks sit a masked processor-state register, a trap base address whose low bits cannot be written, a hypervisor-state register, a floating-point register-state register, a strand status register, primary and secondary context numbers, a partition number, a load/store control register and a bank of scratchpad registers.

Two outputs serve the rest of the core. The first is a packed translation-control word that gathers privilege, address-masking, context and partition fields for the address translation unit. The second is an interrupt request that a write of trap level zero raises. Reads are combinational from the register number. Writes take effect at the rising clock edge. An access to a number with no register behind it, or to a stack when the trap level names no valid entry, returns zero, changes nothing and flags an error in the same cycle.

Top module: `trap_priv_regfile`

## Requirements
- R1: Numbers 0 to 4 (saved PC, saved next PC, saved state, trap type, hypervisor saved state) are five independent stacks of MAX_TL entries. A read or write reaches entry TL-1, so data written at one trap level is not visible at another level or in another stack.
- R2: A write to number 5 (trap base) stores the value with bits 14:0 cleared, and reads return bits 14:0 as zero.
- R3: A write to number 6 (processor state) keeps only bits 1 (ie), 2 (priv), 3 (am), 4 (pef), 7:6 (mm), 8 (tle), 9 (cle) and 11 (pid1), which is mask 0xBDE. Every other bit reads back zero.
- R4: A write to number 7 (trap level) updates `tlz_irq` at that clock edge. The request becomes 1 when hypervisor-state bit 0 (tlz) is set, bit 2 (hpriv) is clear and the new trap level is 0. In every other case it becomes 0. The request holds its value between trap-level writes.
- R5: `mmu_ctl` is built as follows: bit 0 is hypervisor-state bit 2, bit 1 is hypervisor-state bit 5 (red), bit 2 is processor-state bit 2, bit 3 is processor-state bit 3, bits 5:4 are load/store control bits 3:2, bits 15:8 are partition bits 7:0, bits 18:16 are the trap level, bits 47:32 are primary context bits 15:0, bits 63:48 are secondary context bits 15:0, and all other bits are 0.
- R6: After reset, the hypervisor state (number 8) reads 0x800, the strand status (number 10) reads 0x50000, `tlz_irq` is 0, and every other register and stack entry is 0.
- R7: A read of number 9 (floating-point register state) always returns bits 1:0 as 1, whatever value is stored.
- R8: Number 15, and every number at or above 16+NUM_SCR, is unimplemented. A read or write of one returns zero, asserts `access_err` in the same cycle and changes no state.
- R9: An access to a stack number while TL is 0 or TL is greater than MAX_TL returns zero, asserts `access_err` and leaves every stack unchanged.
- R10: Numbers 8 (hypervisor state), 10 (strand status), 11 (primary context), 12 (secondary context), 13 (partition), 14 (load/store control) and 16 to 16+NUM_SCR-1 (scratchpad) store and return all 64 bits. Number 7 stores and returns the low TL_W bits of the written value.
- R11: While `rd_en` is low, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe for `reg_num` |
| wr_en | input | 1 | Write strobe for `reg_num` |
| reg_num | input | 5 | Register number |
| wr_data | input | 64 | Write value |
| rd_data | output | 64 | Read value, combinational |
| access_err | output | 1 | Unimplemented or illegal stack access this cycle |
| mmu_ctl | output | 64 | Packed translation-control word |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |

## Verification
The bench builds the block with its defaults: MAX_TL of 6, a trap level 3 bits wide and eight scratchpad registers. With a 3-bit trap level, the values 0 and 7 can both be written and lie outside the stacks, so both out-of-range cases are reached. Because only the low 3 bits of a trap-level write are kept, a write of 8 lands on level 0 and must raise the interrupt. The full 32-entry number space lets the bench reach the hole at 15 and the unimplemented numbers above the eight scratchpads.

// File: rtl/trp_pkg.sv
package trp_pkg;
   localparam int unsigned RN_W       = 5;
   localparam int unsigned NUM_STACKS = 5;
   localparam int unsigned SCR_BASE   = 16;

   typedef enum logic [RN_W-1:0] {
      RN_TPC     = 5'd0,
      RN_TNPC    = 5'd1,
      RN_TSTATE  = 5'd2,
      RN_TTYPE   = 5'd3,
      RN_HTSTATE = 5'd4,
      RN_TBASE   = 5'd5,
      RN_PSTATE  = 5'd6,
      RN_TLEVEL  = 5'd7,
      RN_HSTATE  = 5'd8,
      RN_FPRS    = 5'd9,
      RN_STRAND  = 5'd10,
      RN_PCTX    = 5'd11,
      RN_SCTX    = 5'd12,
      RN_PART    = 5'd13,
      RN_LSCTL   = 5'd14
   } reg_num_e;

   localparam logic [63:0] PSTATE_KEEP  = 64'h0000_0000_0000_0BDE;
   localparam logic [63:0] TBASE_KEEP   = ~64'h0000_0000_0000_7FFF;
   localparam logic [63:0] HSTATE_RST   = 64'h0000_0000_0000_0800;
   localparam logic [63:0] STRAND_RST   = 64'h0000_0000_0005_0000;
   localparam logic [63:0] FPRS_FORCE   = 64'h0000_0000_0000_0003;

   localparam int unsigned HS_TLZ   = 0;
   localparam int unsigned HS_HPRIV = 2;
   localparam int unsigned HS_RED   = 5;
   localparam int unsigned PS_PRIV  = 2;
   localparam int unsigned PS_AM    = 3;
endpackage

// File: rtl/trp_stack.sv
module trp_stack #(
   parameter int unsigned DEPTH  = 6,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic [DATA_W-1:0] ent_q [DEPTH];
   logic              in_range;

   assign in_range = (idx <= LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else if (we && in_range) begin
         ent_q[idx] <= wdata;
      end
   end

   assign rdata = in_range ? ent_q[idx] : '0;
endmodule

// File: rtl/trp_decode.sv
module trp_decode
   import trp_pkg::*;
#(
   parameter int unsigned MAX_TL  = 6,
   parameter int unsigned TL_W    = 3,
   parameter int unsigned NUM_SCR = 8,
   parameter int unsigned SCR_IW  = $clog2(NUM_SCR)
) (
   input  logic [RN_W-1:0]   reg_num,
   input  logic [TL_W-1:0]   tl,
   output logic              is_stack,
   output logic              scr_hit,
   output logic [SCR_IW-1:0] scr_idx,
   output logic              legal
);
   localparam logic [RN_W:0]   SCR_LO   = (RN_W+1)'(SCR_BASE);
   localparam logic [RN_W:0]   SCR_HI   = (RN_W+1)'(SCR_BASE + NUM_SCR);
   localparam logic [TL_W-1:0] TL_TOP   = TL_W'(MAX_TL);
   localparam logic [RN_W-1:0] STK_LAST = RN_W'(NUM_STACKS);

   logic [RN_W:0] rn_ext;
   logic          stk_ok;
   logic          fixed_hit;

   assign rn_ext    = {1'b0, reg_num};
   assign is_stack  = (reg_num < STK_LAST);
   assign stk_ok    = (tl != '0) && (tl <= TL_TOP);
   assign fixed_hit = (reg_num >= RN_TBASE) && (reg_num <= RN_LSCTL);
   assign scr_hit   = (rn_ext >= SCR_LO) && (rn_ext < SCR_HI);
   assign scr_idx   = reg_num[SCR_IW-1:0];
   assign legal     = (is_stack && stk_ok) || fixed_hit || scr_hit;
endmodule

// File: rtl/trp_mmu_pack.sv
module trp_mmu_pack #(
   parameter int unsigned TL_W = 3
) (
   input  logic            hpriv,
   input  logic            red,
   input  logic            priv,
   input  logic            am,
   input  logic [1:0]      lsu_bits,
   input  logic [7:0]      part,
   input  logic [TL_W-1:0] tl,
   input  logic [15:0]     pctx,
   input  logic [15:0]     sctx,
   output logic [63:0]     word
);
   logic [2:0] tl3;

   if (TL_W >= 3) begin : g_tl_wide
      assign tl3 = tl[2:0];
   end else begin : g_tl_narrow
      assign tl3 = 3'(tl);
   end

   always_comb begin
      word        = '0;
      word[0]     = hpriv;
      word[1]     = red;
      word[2]     = priv;
      word[3]     = am;
      word[5:4]   = lsu_bits;
      word[15:8]  = part;
      word[18:16] = tl3;
      word[47:32] = pctx;
      word[63:48] = sctx;
   end
endmodule

// File: rtl/trap_priv_regfile.sv
module trap_priv_regfile
   import trp_pkg::*;
#(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned MAX_TL  = 6,
   parameter int unsigned TL_W    = 3,
   parameter int unsigned NUM_SCR = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [4:0]        reg_num,
   input  logic [63:0]       wr_data,
   output logic [63:0]       rd_data,
   output logic              access_err,
   output logic [63:0]       mmu_ctl,
   output logic              tlz_irq
);
   localparam int unsigned IDX_W  = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;
   localparam int unsigned SCR_IW = $clog2(NUM_SCR);

   // elaboration-time parameter checks
   if (DATA_W != 64) begin : g_bad_data_w
      $error("trap_priv_regfile: DATA_W must be 64");
   end
   if (MAX_TL < 1 || MAX_TL >= (1 << TL_W)) begin : g_bad_max_tl
      $error("trap_priv_regfile: MAX_TL must be 1..2**TL_W-1");
   end
   if (NUM_SCR < 2 || NUM_SCR > 16) begin : g_bad_num_scr
      $error("trap_priv_regfile: NUM_SCR must be 2..16");
   end
   if (IDX_W > TL_W) begin : g_bad_idx_w
      $error("trap_priv_regfile: stack index wider than trap level");
   end

   logic [DATA_W-1:0] tba_q, pst_q, hps_q, fprs_q, strand_q;
   logic [DATA_W-1:0] pctx_q, sctx_q, part_q, lsctl_q;
   logic [TL_W-1:0]   tl_q;
   logic              tlz_q;
   logic [DATA_W-1:0] scr_q  [NUM_SCR];
   logic [DATA_W-1:0] stk_rd [NUM_STACKS];

   logic              is_stack, scr_hit, legal, wr_ok;
   logic [SCR_IW-1:0] scr_idx;
   logic [IDX_W-1:0]  stk_idx;
   logic [TL_W-1:0]   tl_minus1;
   logic [DATA_W-1:0] rd_val;

   trp_decode #(
      .MAX_TL (MAX_TL),
      .TL_W   (TL_W),
      .NUM_SCR(NUM_SCR),
      .SCR_IW (SCR_IW)
   ) u_decode (
      .reg_num (reg_num),
      .tl      (tl_q),
      .is_stack(is_stack),
      .scr_hit (scr_hit),
      .scr_idx (scr_idx),
      .legal   (legal)
   );

   assign wr_ok      = wr_en && legal;
   assign access_err = (rd_en || wr_en) && !legal;
   assign tl_minus1  = tl_q - TL_W'(1);
   assign stk_idx    = tl_minus1[IDX_W-1:0];

   // one stack per saved-state kind, all indexed by TL-1
   for (genvar s = 0; s < NUM_STACKS; s++) begin : g_stk
      trp_stack #(
         .DEPTH (MAX_TL),
         .DATA_W(DATA_W),
         .IDX_W (IDX_W)
      ) u_stack (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (wr_ok && is_stack && (reg_num == RN_W'(s))),
         .idx  (stk_idx),
         .wdata(wr_data),
         .rdata(stk_rd[s])
      );
   end

   for (genvar k = 0; k < NUM_SCR; k++) begin : g_scr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   scr_q[k] <= '0;
         else if (wr_ok && scr_hit && scr_idx == SCR_IW'(k)) scr_q[k] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tba_q    <= '0;
         pst_q    <= '0;
         hps_q    <= HSTATE_RST;
         fprs_q   <= '0;
         strand_q <= STRAND_RST;
         pctx_q   <= '0;
         sctx_q   <= '0;
         part_q   <= '0;
         lsctl_q  <= '0;
         tl_q     <= '0;
      end else if (wr_ok) begin
         case (reg_num)
            RN_TBASE:  tba_q    <= wr_data & TBASE_KEEP;
            RN_PSTATE: pst_q    <= wr_data & PSTATE_KEEP;
            RN_TLEVEL: tl_q     <= wr_data[TL_W-1:0];
            RN_HSTATE: hps_q    <= wr_data;
            RN_FPRS:   fprs_q   <= wr_data;
            RN_STRAND: strand_q <= wr_data;
            RN_PCTX:   pctx_q   <= wr_data;
            RN_SCTX:   sctx_q   <= wr_data;
            RN_PART:   part_q   <= wr_data;
            RN_LSCTL:  lsctl_q  <= wr_data;
            default:   ;
         endcase
      end
   end

   // trap-level-zero request, re-evaluated on every trap-level write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tlz_q <= 1'b0;
      end else if (wr_ok && reg_num == RN_TLEVEL) begin
         tlz_q <= hps_q[HS_TLZ] && !hps_q[HS_HPRIV] && (wr_data[TL_W-1:0] == '0);
      end
   end
   assign tlz_irq = tlz_q;

   always_comb begin
      rd_val = '0;
      if (is_stack) begin
         for (int s = 0; s < NUM_STACKS; s++) begin
            if (reg_num == RN_W'(s)) rd_val = stk_rd[s];
         end
      end else if (scr_hit) begin
         rd_val = scr_q[scr_idx];
      end else begin
         case (reg_num)
            RN_TBASE:  rd_val = tba_q;
            RN_PSTATE: rd_val = pst_q;
            RN_TLEVEL: rd_val = DATA_W'(tl_q);
            RN_HSTATE: rd_val = hps_q;
            RN_FPRS:   rd_val = fprs_q | FPRS_FORCE;
            RN_STRAND: rd_val = strand_q;
            RN_PCTX:   rd_val = pctx_q;
            RN_SCTX:   rd_val = sctx_q;
            RN_PART:   rd_val = part_q;
            RN_LSCTL:  rd_val = lsctl_q;
            default:   rd_val = '0;
         endcase
      end
   end
   assign rd_data = (rd_en && legal) ? rd_val : '0;

   trp_mmu_pack #(.TL_W(TL_W)) u_mmu_pack (
      .hpriv   (hps_q[HS_HPRIV]),
      .red     (hps_q[HS_RED]),
      .priv    (pst_q[PS_PRIV]),
      .am      (pst_q[PS_AM]),
      .lsu_bits(lsctl_q[3:2]),
      .part    (part_q[7:0]),
      .tl      (tl_q),
      .pctx    (pctx_q[15:0]),
      .sctx    (sctx_q[15:0]),
      .word    (mmu_ctl)
   );
endmodule

// File: rtl/trp_checker.sv
module trp_checker
   import trp_pkg::*;
#(
   parameter int unsigned TL_W    = 3,
   parameter int unsigned NUM_SCR = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_en,
   input logic            wr_en,
   input logic [4:0]      reg_num,
   input logic [TL_W-1:0] tl_wr,
   input logic [63:0]     rd_data,
   input logic            access_err,
   input logic [2:0]      mmu_tl,
   input logic            hs_tlz,
   input logic            hs_hpriv,
   input logic            tlz_irq
);
   localparam logic [5:0] SCR_END = 6'(SCR_BASE + NUM_SCR);

   logic tl_write;
   logic unimpl;
   assign tl_write = wr_en && reg_num == RN_TLEVEL;
   assign unimpl   = (reg_num == 5'd15) || ({1'b0, reg_num} >= SCR_END);

   // R2: trap base never reads back with low bits set
   assert_tbase_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && reg_num == RN_TBASE) |-> (rd_data[14:0] == 15'd0));

   // R7: FP register-state low bits read as ones
   assert_fprs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && reg_num == RN_FPRS) |-> (rd_data[1:0] == 2'b11));

   // R4: request follows the rule on a trap-level write
   assert_tlz_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tl_write && !access_err) |=>
         (tlz_irq == ($past(hs_tlz) && !$past(hs_hpriv) && ($past(tl_wr) == '0))));

   // R4: request holds between trap-level writes
   assert_tlz_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !tl_write |=> $stable(tlz_irq));

   // R8: unimplemented numbers flag an error and read zero
   assert_unimpl_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_en || wr_en) && unimpl) |-> (access_err && rd_data == 64'd0));

   // R9: stack access at trap level zero is illegal
   assert_stack_tl0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_en || wr_en) && reg_num < 5'(NUM_STACKS) && mmu_tl == 3'd0)
         |-> (access_err && rd_data == 64'd0));

   // R11: no read strobe, no data
   assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == 64'd0));
endmodule

bind trap_priv_regfile trp_checker #(.TL_W(TL_W), .NUM_SCR(NUM_SCR)) u_trp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_en     (rd_en),
   .wr_en     (wr_en),
   .reg_num   (reg_num),
   .tl_wr     (wr_data[TL_W-1:0]),
   .rd_data   (rd_data),
   .access_err(access_err),
   .mmu_tl    (mmu_ctl[18:16]),
   .hs_tlz    (hps_q[0]),
   .hs_hpriv  (hps_q[2]),
   .tlz_irq   (tlz_irq)
);

// File: tb/test_trap_priv_regfile.sv
module test_trap_priv_regfile;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        rd_en, wr_en;
   logic [4:0]  reg_num;
   logic [63:0] wr_data;
   logic [63:0] rd_data;
   logic        access_err;
   logic [63:0] mmu_ctl;
   logic        tlz_irq;

   always #5 clk = ~clk;

   trap_priv_regfile i_trap_priv_regfile (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .reg_num(reg_num), .wr_data(wr_data), .rd_data(rd_data),
      .access_err(access_err), .mmu_ctl(mmu_ctl), .tlz_irq(tlz_irq));

   int    checks = 0;
   int    failures = 0;
   bit    done = 0;
   string phase = "init";

   // behavioural reference state
   logic [63:0] m_stk [5][6];
   logic [63:0] m_scr [8];
   logic [63:0] m_tba, m_pst, m_hps, m_fprs, m_strand, m_pctx, m_sctx, m_part, m_lsu;
   int          m_tl;
   bit          m_irq;

   function automatic bit m_legal(int a);
      if (a < 5) return (m_tl >= 1 && m_tl <= 6);
      if (a >= 5 && a <= 14) return 1;
      if (a >= 16 && a < 24) return 1;
      return 0;
   endfunction

   function automatic logic [63:0] m_val(int a);
      if (a < 5) return m_stk[a][m_tl-1];
      if (a >= 16) return m_scr[a-16];
      case (a)
         5:  return m_tba;
         6:  return m_pst;
         7:  return 64'(m_tl);
         8:  return m_hps;
         9:  return m_fprs | 64'h3;
         10: return m_strand;
         11: return m_pctx;
         12: return m_sctx;
         13: return m_part;
         14: return m_lsu;
         default: return 64'h0;
      endcase
   endfunction

   function automatic logic [63:0] m_mmu();
      logic [63:0] w = 64'h0;
      w[0] = m_hps[2];
      w[1] = m_hps[5];
      w[2] = m_pst[2];
      w[3] = m_pst[3];
      w[5:4] = m_lsu[3:2];
      w[15:8] = m_part[7:0];
      w[18:16] = 3'(m_tl);
      w[47:32] = m_pctx[15:0];
      w[63:48] = m_sctx[15:0];
      return w;
   endfunction

   task automatic m_write(int a, logic [63:0] d);
      if (a < 5) m_stk[a][m_tl-1] = d;
      else if (a >= 16) m_scr[a-16] = d;
      else case (a)
         5:  m_tba = d & ~64'h7FFF;
         6:  m_pst = d & 64'hBDE;
         7: begin
            m_irq = m_hps[0] && !m_hps[2] && ((d & 64'h7) == 0);
            m_tl  = int'(d & 64'h7);
         end
         8:  m_hps = d;
         9:  m_fprs = d;
         10: m_strand = d;
         11: m_pctx = d;
         12: m_sctx = d;
         13: m_part = d;
         14: m_lsu = d;
         default: ;
      endcase
   endtask

   function automatic string tag_of(int a);
      if (a < 5) return "R1";
      if (a == 5) return "R2";
      if (a == 6) return "R3";
      if (a == 9) return "R7";
      if (a == 15 || a >= 24) return "R8";
      return "R10";
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL [%s] %s actual=%h expected=%h", phase, tag, act, exp);
      end
   endtask

   // one bus cycle: drive at falling edge, compare, let the rising edge act
   task automatic op(bit rd, bit wr, int a, logic [63:0] d);
      bit ok;
      @(negedge clk);
      rd_en = rd; wr_en = wr; reg_num = 5'(a); wr_data = d;
      #1;
      ok = m_legal(a);
      chk(rd ? (ok ? tag_of(a) : (a < 5 ? "R9 rd" : "R8 rd")) : "R11 rd idle",
          rd_data, (rd && ok) ? m_val(a) : 64'h0);
      chk(ok ? "R8 R9 err clear" : (a < 5 ? "R9 err" : "R8 err"),
          64'(access_err), 64'((rd || wr) && !ok));
      chk("R5 mmu", mmu_ctl, m_mmu());
      chk("R4 irq", 64'(tlz_irq), 64'(m_irq));
      @(posedge clk);
      if (wr && ok) m_write(a, d);
   endtask

   task automatic rd(int a);
      op(1, 0, a, 64'h0);
   endtask

   task automatic wr(int a, logic [63:0] d);
      op(0, 1, a, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 5; s++) for (int l = 0; l < 6; l++) m_stk[s][l] = 64'h0;
      for (int k = 0; k < 8; k++) m_scr[k] = 64'h0;
      m_tba = 0; m_pst = 0; m_hps = 64'h800; m_fprs = 0; m_strand = 64'h50000;
      m_pctx = 0; m_sctx = 0; m_part = 0; m_lsu = 0; m_tl = 0; m_irq = 0;

      rst_n = 1'b0; rd_en = 0; wr_en = 0; reg_num = 0; wr_data = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      phase = "R6 reset";
      #1;
      chk("R6 mmu reset", mmu_ctl, 64'h0);
      chk("R6 irq reset", 64'(tlz_irq), 64'h0);
      for (int a = 0; a < 32; a++) rd(a);

      phase = "R3 pstate mask";
      wr(6, 64'hFFFF_FFFF_FFFF_FFFF); rd(6);
      wr(6, 64'h0000_0000_0000_0421); rd(6);

      phase = "R2 trap base";
      wr(5, 64'hFFFF_FFFF_FFFF_FFFF); rd(5);
      wr(5, 64'h1234_5678_9ABC_8001); rd(5);

      phase = "R7 fprs";
      wr(9, 64'h0); rd(9);
      wr(9, 64'h4); rd(9);

      phase = "R9 stack at level 0";
      wr(0, 64'hDEAD); wr(4, 64'hBEEF); rd(0); rd(4);

      phase = "R1 stack fill";
      for (int l = 1; l <= 6; l++) begin
         wr(7, 64'(l));
         for (int s = 0; s < 5; s++) wr(s, {32'(l), 32'(s) ^ 32'hA5A5_0000});
      end
      phase = "R1 stack readback";
      for (int l = 6; l >= 1; l--) begin
         wr(7, 64'(l));
         for (int s = 0; s < 5; s++) rd(s);
      end

      phase = "R9 level above max";
      wr(7, 64'd7); wr(2, 64'h5555); rd(2); rd(0);
      wr(7, 64'd6); rd(2);

      phase = "R4 tlz";
      wr(8, 64'h801); wr(7, 64'd0); rd(7);
      wr(7, 64'd3);
      wr(8, 64'h805); wr(7, 64'd0);
      wr(8, 64'h001); wr(7, 64'd8); rd(7);
      rd(8); rd(8);
      wr(8, 64'h000); wr(7, 64'd0);

      phase = "R5 mmu fields";
      wr(8, 64'h24); wr(6, 64'hC);
      wr(14, 64'hFFFF_FFFF_FFFF_FFF3); wr(13, 64'hAB_CD);
      wr(11, 64'h1111_2222_3333_BEEF); wr(12, 64'h4444_5555_6666_F00D);
      wr(7, 64'd5); rd(11);

      phase = "R10 plain regs";
      for (int k = 16; k < 24; k++) wr(k, {32'hC0DE_0000 + 32'(k), 32'(k) * 32'h0101_0101});
      for (int k = 16; k < 24; k++) rd(k);
      wr(10, 64'hFEDC_BA98_7654_3210); rd(10);

      phase = "R8 unimplemented";
      wr(15, 64'hFFFF); wr(24, 64'h1); wr(31, 64'h2);
      rd(15); rd(24); rd(31);
      op(1, 1, 15, 64'h3);

      phase = "R11 idle";
      op(0, 0, 9, 64'h0); op(0, 0, 16, 64'h0);

      phase = "mixed";
      for (int n = 0; n < 3000; n++) begin
         int a = int'($urandom_range(0, 31));
         logic [63:0] d = {$urandom, $urandom};
         if (a == 7) d = 64'($urandom_range(0, 8));
         if (a == 8 && $urandom_range(0, 1) == 1) d = d & 64'h1;
         op($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, d);
      end
      op(0, 0, 0, 64'h0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule